// File: doc/BRIEF.md
# Fractional Reference Clock Generator

This block produces a reference clock from one of up to sixteen source clocks. The source is picked by a select field. The block divides that source by 2×(N + M/512): N is a 15-bit integer divisor and M is a 9-bit trim. If N is zero, the selected source goes to the output without division. The fractional part works through a 9-bit phase accumulator. Every output half-period adds M to it, and each time the sum passes 512 the next half-period is one source cycle longer.

The block runs on one system clock. It samples the source clocks through two-flop synchronisers and counts rising edges of the selected one, so each source must toggle more slowly than the system clock. Software uses a control word and a trim word at byte offset 0x10. Writes to the N and M fields go to shadow copies. The running divider picks them up only after software sets the switch request bit. If the divider is running, the new values take effect at the next half-period boundary. Hardware clears the request bit once the values are loaded. An active flag shows that the divider is running, and while it is set the block refuses changes to the source select.

Top module: `refclk_gen`

## Requirements
- R1: After reset both register words read 0 and `ref_out` is low.
- R2: Control word fields: source select at bits 3:0, active flag at bit 8 (read only), switch request at bit 9, output enable at bit 12, run bit at bit 15, N at bits 30:16. The trim word at byte offset 0x10 holds M at bits 31:23. Every other bit reads 0. A read returns data one clock after the address is presented.
- R3: With M = 0 and N > 0, every output half-period lasts exactly N rising edges of the selected source.
- R4: With M > 0, half-period k lasts N + c(k) source edges. c(0) = 0. Each boundary adds M to a 9-bit accumulator, and c(k+1) = 1 if that sum reached 512. The accumulator starts at 0 after a load and whenever the run bit is cleared.
- R5: With N = 0 and the block enabled, `ref_out` follows the synchronised selected source: one output rising edge for every source rising edge.
- R6: Writes to N and M do not change the running divider until bit 9 of the control word is written as 1. Bit 9 reads 1 while the load is pending and reads 0 after it is done.
- R7: A load requested while the divider is running takes effect at the next half-period boundary. The half-period in progress still finishes with the old length.
- R8: The active flag equals the run bit delayed by one clock. A write to the source select while the active flag is 1 is ignored.
- R9: With the run bit set and the output enable clear, the divider runs and the active flag reads 1, but `ref_out` stays low.
- R10: With the run bit clear, `ref_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_clk | input | NSRC | Source clocks, sampled asynchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write byte address (0x00 control, 0x10 trim) |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read byte address |
| rd_data | output | 32 | Registered read data |
| ref_out | output | 1 | Generated reference clock |

## Verification
The checker watches several rules on every cycle. The active flag must follow the run bit, and the select must stay fixed while active is set. The output must stay low whenever the run bit or the enable is clear. The request bit must clear after a load, and the half-period counter must stay within N. Only the bench scenarios can show that the sequence of half-period lengths matches the accumulator model, that a switch while running waits for the boundary, and that pass-through keeps up with the source edge for edge. The bench shows these by counting source edges between output transitions.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int DATA_W   = 32;
  localparam int SEL_W    = 4;
  localparam int SEL_LSB  = 0;
  localparam int ACT_BIT  = 8;
  localparam int SW_BIT   = 9;
  localparam int OE_BIT   = 12;
  localparam int RUN_BIT  = 15;
  localparam int N_W      = 15;
  localparam int N_LSB    = 16;
  localparam int M_W      = 9;
  localparam int M_LSB    = 23;
  localparam int CTRL_OFS = 0;
  localparam int TRIM_OFS = 16;
endpackage

// File: rtl/refclk_regs.sv
module refclk_regs
  import refclk_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  input  logic              load_done,
  output logic [DATA_W-1:0] rd_data,
  output logic [SEL_W-1:0]  sel,
  output logic              run,
  output logic              oe,
  output logic              active,
  output logic              sw_req,
  output logic [N_W-1:0]    n_shadow,
  output logic [M_W-1:0]    m_shadow
);
  logic ctrl_wr, trim_wr;
  logic [DATA_W-1:0] ctrl_word, trim_word;

  assign ctrl_wr = wr_en && (wr_addr == AW'(CTRL_OFS));
  assign trim_wr = wr_en && (wr_addr == AW'(TRIM_OFS));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel      <= '0;
      run      <= 1'b0;
      oe       <= 1'b0;
      active   <= 1'b0;
      sw_req   <= 1'b0;
      n_shadow <= '0;
      m_shadow <= '0;
    end else begin
      active <= run;
      if (ctrl_wr) begin
        if (!active) sel <= wr_data[SEL_LSB +: SEL_W];
        oe       <= wr_data[OE_BIT];
        run      <= wr_data[RUN_BIT];
        n_shadow <= wr_data[N_LSB +: N_W];
      end
      if (trim_wr) m_shadow <= wr_data[M_LSB +: M_W];
      if (ctrl_wr && wr_data[SW_BIT]) sw_req <= 1'b1;
      else if (load_done)             sw_req <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[SEL_LSB +: SEL_W] = sel;
    ctrl_word[ACT_BIT]          = active;
    ctrl_word[SW_BIT]           = sw_req;
    ctrl_word[OE_BIT]           = oe;
    ctrl_word[RUN_BIT]          = run;
    ctrl_word[N_LSB +: N_W]     = n_shadow;
    trim_word = '0;
    trim_word[M_LSB +: M_W]     = m_shadow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_addr == AW'(CTRL_OFS)) begin
      rd_data <= ctrl_word;
    end else if (rd_addr == AW'(TRIM_OFS)) begin
      rd_data <= trim_word;
    end else begin
      rd_data <= '0;
    end
  end
endmodule

// File: rtl/refclk_srcsel.sv
module refclk_srcsel #(
  parameter int NSRC  = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_clk,
  input  logic [SEL_W-1:0] sel,
  output logic             src_lvl,
  output logic             src_rise
);
  logic [NSRC-1:0] meta_q;
  logic [NSRC-1:0] sync_q;
  logic            prev_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= src_clk[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  always_comb begin
    src_lvl = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (int'(sel) == i) src_lvl = sync_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= src_lvl;
  end

  assign src_rise = src_lvl && !prev_q;
endmodule

// File: rtl/refclk_fracdiv.sv
module refclk_fracdiv #(
  parameter int N_W = 15,
  parameter int M_W = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           oe,
  input  logic           src_lvl,
  input  logic           src_rise,
  input  logic [N_W-1:0] n_shadow,
  input  logic [M_W-1:0] m_shadow,
  input  logic           load_req,
  output logic           load_done,
  output logic           ref_q,
  output logic [N_W-1:0] n_run,
  output logic [N_W-1:0] cnt_q
);
  localparam int CW = N_W + 1;

  logic [M_W-1:0] m_run, acc_q;
  logic           extra_q, phase_q;
  logic           div_mode, running, boundary;
  logic [CW-1:0]  target, cnt_nxt;
  logic [M_W:0]   acc_sum;

  assign div_mode  = (n_run != '0);
  assign running   = run && div_mode;
  assign target    = {1'b0, n_run} + CW'(extra_q);
  assign cnt_nxt   = {1'b0, cnt_q} + CW'(1);
  assign boundary  = running && src_rise && (cnt_nxt >= target);
  assign load_done = load_req && (boundary || !running);
  assign acc_sum   = {1'b0, acc_q} + {1'b0, m_run};

  always_ff @(posedge clk) begin
    if (rst) begin
      n_run   <= '0;
      m_run   <= '0;
      acc_q   <= '0;
      extra_q <= 1'b0;
      cnt_q   <= '0;
    end else if (load_done) begin
      n_run   <= n_shadow;
      m_run   <= m_shadow;
      acc_q   <= '0;
      extra_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!running) begin
      acc_q   <= '0;
      extra_q <= 1'b0;
      cnt_q   <= '0;
    end else if (boundary) begin
      acc_q   <= acc_sum[M_W-1:0];
      extra_q <= acc_sum[M_W];
      cnt_q   <= '0;
    end else if (src_rise) begin
      cnt_q   <= cnt_nxt[N_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      ref_q   <= 1'b0;
    end else begin
      if (!running)     phase_q <= 1'b0;
      else if (boundary) phase_q <= ~phase_q;
      ref_q <= run && oe && (div_mode ? phase_q : src_lvl);
    end
  end
endmodule

// File: rtl/refclk_gen.sv
module refclk_gen
  import refclk_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int AW   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ref_out
);
  logic [SEL_W-1:0] sel;
  logic             run, oe, active, sw_req, load_done;
  logic [N_W-1:0]   n_shadow, n_run, cnt_q;
  logic [M_W-1:0]   m_shadow;
  logic             src_lvl, src_rise;

  refclk_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .load_done(load_done), .rd_data(rd_data), .sel(sel),
    .run(run), .oe(oe), .active(active), .sw_req(sw_req),
    .n_shadow(n_shadow), .m_shadow(m_shadow)
  );

  refclk_srcsel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_src (
    .clk(clk), .rst(rst), .src_clk(src_clk), .sel(sel),
    .src_lvl(src_lvl), .src_rise(src_rise)
  );

  refclk_fracdiv #(.N_W(N_W), .M_W(M_W)) u_div (
    .clk(clk), .rst(rst), .run(run), .oe(oe), .src_lvl(src_lvl),
    .src_rise(src_rise), .n_shadow(n_shadow), .m_shadow(m_shadow),
    .load_req(sw_req), .load_done(load_done), .ref_q(ref_out),
    .n_run(n_run), .cnt_q(cnt_q)
  );
endmodule

// File: rtl/refclk_gen_chk.sv
module refclk_gen_chk
  import refclk_pkg::*;
#(
  parameter int AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [SEL_W-1:0]  sel,
  input logic              run,
  input logic              oe,
  input logic              active,
  input logic              sw_req,
  input logic              load_done,
  input logic [N_W-1:0]    n_run,
  input logic [N_W-1:0]    cnt_q,
  input logic              ref_out
);
  logic sw_set;
  assign sw_set = wr_en && (wr_addr == AW'(CTRL_OFS)) && wr_data[SW_BIT];

  // R1
  a_r1_reset_low: assert property (@(posedge clk) rst |=> !ref_out);

  // R8
  a_r8_active_tracks_run: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (active == $past(run)));

  // R8
  a_r8_sel_locked: assert property (@(posedge clk) disable iff (rst)
    active |=> $stable(sel));

  // R9
  a_r9_oe_gates: assert property (@(posedge clk) disable iff (rst)
    !oe |=> !ref_out);

  // R10
  a_r10_off_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> !ref_out);

  // R6
  a_r6_req_clears: assert property (@(posedge clk) disable iff (rst)
    (load_done && !sw_set) |=> !sw_req);

  // R3
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    (run && n_run != '0) |-> (cnt_q <= n_run));
endmodule

bind refclk_gen refclk_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .sel(sel), .run(run), .oe(oe), .active(active), .sw_req(sw_req),
  .load_done(load_done), .n_run(n_run), .cnt_q(cnt_q), .ref_out(ref_out)
);

// File: tb/test_refclk_gen.sv
module test_refclk_gen;
  localparam int NSRC = 16;
  localparam int AW   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] src_clk = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic ref_out;

  refclk_gen #(.NSRC(NSRC), .AW(AW)) i_refclk_gen (
    .clk(clk), .rst(rst), .src_clk(src_clk), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ref_out(ref_out)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int src_cnt [NSRC];
  int cur_sel = 0, edge_cnt = 0, last_len = 0, tog = 0;
  int ref_rises = 0, src_rises = 0;
  logic ref_prev = 1'b0;
  int acc_m = 0, ex_m = 0;

  initial for (int i = 0; i < NSRC; i++) src_cnt[i] = 0;

  // source generators and interval measurement in one process
  always @(negedge clk) begin
    if (ref_out !== ref_prev) begin
      last_len = edge_cnt;
      edge_cnt = 0;
      tog++;
      if (ref_out) ref_rises++;
    end
    ref_prev = ref_out;
    for (int i = 0; i < NSRC; i++) begin
      src_cnt[i]++;
      if (src_cnt[i] >= 3 + (i % 5)) begin
        src_cnt[i] = 0;
        src_clk[i] = ~src_clk[i];
        if (src_clk[i] && i == cur_sel) begin
          edge_cnt++;
          src_rises++;
        end
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<190000", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int addr, output logic [31:0] d);
    @(negedge clk);
    rd_addr = AW'(addr);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic wait_tog(output int len);
    int c0;
    c0 = tog;
    while (tog == c0) @(posedge clk);
    len = last_len;
  endtask

  function automatic logic [31:0] ctrl(int sel, int n, bit sw, bit oe, bit on);
    return (32'(n) << 16) | (32'(on) << 15) | (32'(oe) << 12) | (32'(sw) << 9) | 32'(sel);
  endfunction

  function int model_next(int n, int m);
    int len, sum;
    len = n + ex_m;
    sum = acc_m + m;
    acc_m = sum % 512;
    ex_m = (sum >= 512) ? 1 : 0;
    return len;
  endfunction

  // stop, select, load while stopped, enable; discard first half-period
  task automatic start(int sel, int n, int m);
    int len;
    wr(0, 32'h0);
    idle(3);
    wr(0, ctrl(sel, 0, 0, 0, 0));
    cur_sel = sel;
    wr(16, 32'(m) << 23);
    wr(0, ctrl(sel, n, 1, 0, 0));
    wr(0, ctrl(sel, n, 0, 1, 1));
    acc_m = 0; ex_m = 0;
    if (n != 0) begin
      len = model_next(n, m);
      wait_tog(len);
    end
  endtask

  task automatic run_cmp(string req, int n, int m, int count);
    int len;
    for (int k = 0; k < count; k++) begin
      wait_tog(len);
      check(req, len, model_next(n, m));
    end
  endtask

  initial begin
    logic [31:0] d;
    int len, n, m, sel, r0, s0;
    void'($urandom(32'd20240607));
    idle(5);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(0, d);  check("R1 ctrl", d, 32'h0);
    rd(16, d); check("R1 trim", d, 32'h0);
    check("R1 ref_out", ref_out, 0);

    // R2 field layout and readback
    wr(0, 32'h1234_1005);
    rd(0, d);  check("R2 ctrl", d, 32'h1234_1005);
    wr(16, 32'hD280_0ABC);
    rd(16, d); check("R2 trim", d, 32'hD280_0000);
    wr(4, 32'hFFFF_FFFF);
    rd(4, d);  check("R2 unmapped", d, 32'h0);

    // R6 shadow writes are held until switch request
    start(2, 3, 0);
    run_cmp("R3 base", 3, 0, 4);
    wr(16, 32'(256) << 23);
    wr(0, ctrl(2, 5, 0, 1, 1));
    run_cmp("R6 no switch", 3, 0, 4);
    // R7 switch while running waits for boundary
    wait_tog(len);
    wr(0, ctrl(2, 5, 1, 1, 1));
    rd(0, d); check("R6 pending", (d >> 9) & 1, 1);
    wait_tog(len); check("R7 old length", len, 3);
    rd(0, d); check("R6 cleared", (d >> 9) & 1, 0);
    acc_m = 0; ex_m = 0;
    run_cmp("R7 new values", 5, 256, 10);

    // R3 integer division, random N and source
    for (int r = 0; r < 3; r++) begin
      n = 1 + int'($urandom_range(5)); sel = int'($urandom_range(15));
      start(sel, n, 0);
      run_cmp("R3 integer", n, 0, 10);
    end

    // R4 fractional: directed corners then random
    start(4, 1, 511); run_cmp("R4 m511", 1, 511, 24);
    start(7, 1, 256); run_cmp("R4 half", 1, 256, 16);
    for (int r = 0; r < 4; r++) begin
      n = 1 + int'($urandom_range(4)); m = 1 + int'($urandom_range(510));
      sel = int'($urandom_range(15));
      start(sel, n, m);
      run_cmp("R4 random", n, m, 24);
    end

    // R8 select locked while active
    wr(0, ctrl(9, 4, 0, 1, 1));
    rd(0, d);
    check("R8 active bit", (d >> 8) & 1, 1);
    check("R8 sel held", d & 32'hF, 32'(sel));
    wr(0, ctrl(sel, 4, 0, 1, 0));
    idle(3);
    rd(0, d); check("R8 active low", (d >> 8) & 1, 0);
    wr(0, ctrl(9, 4, 0, 1, 0));
    rd(0, d); check("R8 sel free", d & 32'hF, 32'd9);

    // R9 running without output enable
    start(1, 2, 0);
    wr(0, ctrl(1, 2, 0, 0, 1));
    idle(3);
    r0 = ref_rises;
    rd(0, d); check("R9 active", (d >> 8) & 1, 1);
    idle(200);
    check("R9 no edges", ref_rises - r0, 0);
    check("R9 low", ref_out, 0);

    // R10 run bit cleared
    wr(0, ctrl(1, 2, 0, 1, 1));
    idle(60);
    wr(0, ctrl(1, 2, 0, 1, 0));
    idle(3);
    r0 = ref_rises;
    idle(200);
    check("R10 no edges", ref_rises - r0, 0);
    check("R10 low", ref_out, 0);

    // R5 pass-through
    start(0, 0, 0);
    idle(20);
    r0 = ref_rises; s0 = src_rises;
    idle(300);
    len = (src_rises - s0) - (ref_rises - r0);
    check("R5 edge match", (len >= -1 && len <= 1) ? 1 : 0, 1);
    check("R5 activity", (src_rises - s0 > 10) ? 1 : 0, 1);

    summary();
    $finish;
  end
endmodule